// File: doc/BRIEF.md
# Frame Scanout Checksum Unit

This block sits beside the parallel pixel output of a display controller and folds every pixel word that leaves it into a running CRC32. A start-of-frame marker seeds the checksum, and each qualified word is fed in. The word that carries the end-of-frame marker is the last one included. When the frame closes, the finished value is captured into a read-only status register and a frame-done flag is raised. Software responds to the flag, reads the checksum and compares it with what it meant to display.

The arithmetic uses the reflected CRC32 polynomial 0xEDB88320. Each input word is bit-reversed before it is shifted in, the register starts at all ones for every frame, and the result is bit-reversed once more before it is exposed. No final XOR is applied. This is the same as a non-reflected CRC with polynomial 0x04C11DB7, all-ones seed, words fed most significant bit first, and no output inversion.

A two-state sequencer controls the datapath. In `ST_WAIT` the unit is outside a frame. The transition *frame open* (valid word with start marker) moves it to `ST_ACTIVE`. In `ST_ACTIVE` the transition *frame close* (valid word with end marker) latches the result and returns to `ST_WAIT`. The transition *frame restart* (valid word with start marker while active) reseeds the checksum without leaving `ST_ACTIVE`. A valid word that carries both markers while in `ST_WAIT` opens and closes a one-word frame, staying in `ST_WAIT`.

Top module: `scan_crc_unit`

## Requirements
- R1: After reset the status register, the done flag, the interrupt enable and `irq` are all zero.
- R2: The status value is the CRC32 of the frame's words using the reflected polynomial 0xEDB88320 over bit-reversed words, with the result bit-reversed and no final XOR. This equals the MSB-first CRC with polynomial 0x04C11DB7 and no output inversion.
- R3: Every frame starts from 0xFFFFFFFF, so a frame's checksum does not depend on any earlier frame.
- R4: Only cycles with `pix_valid` high advance the checksum. Idle cycles inside a frame leave the result unchanged.
- R5: The word carrying `pix_eof` is included. The status register takes the new value on that same clock edge and holds it until the next frame closes.
- R6: Closing a frame sets the done flag, which reads back as bit 0 at offset 0x040.
- R7: Writing a 1 to bit 0 of the clear alias at offset 0x044 clears the done flag. Writing a 0 there has no effect.
- R8: Bit 1 at offset 0x040 is a writable interrupt enable, and `irq` is high exactly when both the flag and the enable are set.
- R9: The checksum reads at offset 0x1A0, and writes to that offset are ignored.
- R10: A frame that closes before software reads the previous result overwrites the status register, and the flag stays set.
- R11: Valid words outside a frame are ignored. A start marker inside an open frame discards the partial checksum and restarts from the seed.
- R12: The smallest frame of 16 words (8 pixels by 2 lines) produces a correct checksum.
- R13: When a frame closes in the same cycle as a clear write, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pix_valid | input | 1 | Pixel word qualifier |
| pix_word | input | 32 | Pixel word leaving the output |
| pix_sof | input | 1 | Marks the first word of a frame |
| pix_eof | input | 1 | Marks the last word of a frame |
| reg_addr | input | 12 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| irq | output | 1 | Frame-done interrupt |

## Verification
The bench builds the unit with its default parameters: 32-bit words, a 12-bit offset space and the standard polynomial and seed. With these, the 0x1A0 offset is reachable and the checksum can be compared with an independent MSB-first CRC model. Frames of 16 words and longer are driven contiguously, with idle gaps, back to back without reads, and with an aborted partial frame in front. These patterns bring seeding, gap handling, overwrite and restart within reach. A clear write placed on the closing cycle exercises the set-over-clear priority.

// File: rtl/scan_crc_pkg.sv
package scan_crc_pkg;
    localparam int unsigned WORD_W_DEF  = 32;
    localparam int unsigned ADDR_W_DEF  = 12;

    typedef enum logic [0:0] {
        ST_WAIT   = 1'b0,
        ST_ACTIVE = 1'b1
    } seq_state_e;
endpackage

// File: rtl/crc_word_engine.sv
module crc_word_engine #(
    parameter int unsigned       W    = 32,
    parameter logic [W-1:0]      POLY = 32'hEDB88320,
    parameter logic [W-1:0]      SEED = 32'hFFFFFFFF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         seed_en,
    input  logic         step_en,
    input  logic [W-1:0] din,
    output logic [W-1:0] result_rev
);
    logic [W-1:0] crc_q;
    logic [W-1:0] base;
    logic [W-1:0] din_rev;
    logic [W-1:0] chain [W+1];

    assign base     = seed_en ? SEED : crc_q;
    assign chain[0] = base;

    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            assign din_rev[i]  = din[W-1-i];
            assign chain[i+1]  = {1'b0, chain[i][W-1:1]}
                               ^ ((chain[i][0] ^ din_rev[i]) ? POLY : '0);
            assign result_rev[i] = chain[W][W-1-i];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= SEED;
        end else if (step_en) begin
            crc_q <= chain[W];
        end
    end
endmodule

// File: rtl/frame_seq_fsm.sv
module frame_seq_fsm
    import scan_crc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vld,
    input  logic       sof,
    input  logic       eof,
    output logic       seed_en,
    output logic       step_en,
    output logic       close_stb,
    output seq_state_e state
);
    seq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT: begin
                if (vld && sof && !eof) state_d = ST_ACTIVE;   // frame open
            end
            ST_ACTIVE: begin
                if (vld && eof) state_d = ST_WAIT;             // frame close
            end
            default: state_d = ST_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_WAIT;
        else        state_q <= state_d;
    end

    always_comb begin
        seed_en   = 1'b0;
        step_en   = 1'b0;
        close_stb = 1'b0;
        unique case (state_q)
            ST_WAIT: begin
                if (vld && sof) begin
                    seed_en   = 1'b1;
                    step_en   = 1'b1;
                    close_stb = eof;
                end
            end
            ST_ACTIVE: begin
                if (vld) begin
                    seed_en   = sof;        // frame restart
                    step_en   = 1'b1;
                    close_stb = eof;
                end
            end
            default: ;
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/crc_csr.sv
module crc_csr #(
    parameter int unsigned    W        = 32,
    parameter int unsigned    AW       = 12,
    parameter logic [AW-1:0]  OFF_CTL  = 12'h040,
    parameter logic [AW-1:0]  OFF_CLR  = 12'h044,
    parameter logic [AW-1:0]  OFF_STAT = 12'h1A0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          close_stb,
    input  logic [W-1:0]  result,
    input  logic [AW-1:0] addr,
    input  logic          wr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata,
    output logic          irq,
    output logic          clr_stb,
    output logic          flag_q,
    output logic          en_q,
    output logic [W-1:0]  status_q
);
    logic ctl_wr;

    assign ctl_wr  = wr && (addr == OFF_CTL);
    assign clr_stb = wr && (addr == OFF_CLR) && wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
            flag_q   <= 1'b0;
            en_q     <= 1'b0;
        end else begin
            if (close_stb)    status_q <= result;
            if (close_stb)    flag_q   <= 1'b1;
            else if (clr_stb) flag_q   <= 1'b0;
            if (ctl_wr)       en_q     <= wdata[1];
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == OFF_CTL)       rdata[1:0] = {en_q, flag_q};
        else if (addr == OFF_STAT) rdata      = status_q;
    end

    assign irq = flag_q & en_q;
endmodule

// File: rtl/scan_crc_unit.sv
module scan_crc_unit
    import scan_crc_pkg::*;
#(
    parameter int unsigned              WORD_W   = WORD_W_DEF,
    parameter int unsigned              ADDR_W   = ADDR_W_DEF,
    parameter logic [WORD_W-1:0]        POLY     = 32'hEDB88320,
    parameter logic [WORD_W-1:0]        SEED     = 32'hFFFFFFFF,
    parameter logic [ADDR_W-1:0]        OFF_CTL  = 12'h040,
    parameter logic [ADDR_W-1:0]        OFF_CLR  = 12'h044,
    parameter logic [ADDR_W-1:0]        OFF_STAT = 12'h1A0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_valid,
    input  logic [WORD_W-1:0] pix_word,
    input  logic              pix_sof,
    input  logic              pix_eof,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              irq
);
    logic              seed_w, step_w, frame_end;
    logic              clr_hit, flag_bit, en_bit;
    logic [WORD_W-1:0] result_w, status_val;
    seq_state_e        seq_state;

    frame_seq_fsm u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .vld       (pix_valid),
        .sof       (pix_sof),
        .eof       (pix_eof),
        .seed_en   (seed_w),
        .step_en   (step_w),
        .close_stb (frame_end),
        .state     (seq_state)
    );

    crc_word_engine #(.W(WORD_W), .POLY(POLY), .SEED(SEED)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .seed_en    (seed_w),
        .step_en    (step_w),
        .din        (pix_word),
        .result_rev (result_w)
    );

    crc_csr #(
        .W(WORD_W), .AW(ADDR_W),
        .OFF_CTL(OFF_CTL), .OFF_CLR(OFF_CLR), .OFF_STAT(OFF_STAT)
    ) u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .close_stb (frame_end),
        .result    (result_w),
        .addr      (reg_addr),
        .wr        (reg_wr),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .irq       (irq),
        .clr_stb   (clr_hit),
        .flag_q    (flag_bit),
        .en_q      (en_bit),
        .status_q  (status_val)
    );
endmodule

// File: rtl/scan_crc_sva.sv
module scan_crc_sva #(
    parameter int unsigned W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         frame_end,
    input logic         clr_hit,
    input logic         flag_bit,
    input logic         en_bit,
    input logic         irq,
    input logic [W-1:0] status_val
);
    AST_FLAG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_bit) |-> $past(frame_end)); // R6
    AST_CLOSE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> flag_bit); // R13
    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(frame_end) |-> $stable(status_val)); // R5
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_hit && !frame_end) |=> !flag_bit); // R7
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(frame_end) || !$past(en_bit))); // R8
endmodule

bind scan_crc_unit scan_crc_sva #(.W(WORD_W)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_end  (frame_end),
    .clr_hit    (clr_hit),
    .flag_bit   (flag_bit),
    .en_bit     (en_bit),
    .irq        (irq),
    .status_val (status_val)
);

// File: tb/sim_scan_crc_unit.sv
module sim_scan_crc_unit;
    localparam int CLK_NS = 20;
    localparam logic [11:0] A_CTL  = 12'h040;
    localparam logic [11:0] A_CLR  = 12'h044;
    localparam logic [11:0] A_STAT = 12'h1A0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vld = 1'b0, sof = 1'b0, eof = 1'b0, wr = 1'b0;
    logic [31:0] data = '0, wdata = '0, rdata;
    logic [11:0] addr = '0;
    logic        irq;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    logic [31:0] fw [64];

    always #(CLK_NS/2) clk = ~clk;

    scan_crc_unit u0 (
        .clk(clk), .rst_n(rst_n), .pix_valid(vld), .pix_word(data),
        .pix_sof(sof), .pix_eof(eof), .reg_addr(addr), .reg_wr(wr),
        .reg_wdata(wdata), .reg_rdata(rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model(input int n);
        logic [31:0] c = 32'hFFFFFFFF;
        for (int i = 0; i < n; i++)
            for (int b = 31; b >= 0; b--) begin
                logic fb = c[31] ^ fw[i][b];
                c = c << 1;
                if (fb) c = c ^ 32'h04C11DB7;
            end
        return c;
    endfunction

    task automatic fill(input logic [31:0] k);
        for (int i = 0; i < 64; i++) fw[i] = (k * (i + 1)) ^ (32'h9E3779B9 >> (i % 7)) ^ (i << 9);
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        addr = a; #1 v = rdata;
    endtask

    task automatic wreg(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; wr = 1'b1; wdata = d;
        @(negedge clk); wr = 1'b0; wdata = '0;
    endtask

    task automatic frame(input int n, input int gap, input bit clr_last, output logic [31:0] pre);
        pre = '0;
        for (int i = 0; i < n; i++) begin
            if (gap > 0 && i > 0 && (i % gap) == 0) begin
                @(negedge clk); vld = 1'b0; sof = 1'b0; eof = 1'b0;
            end
            @(negedge clk); vld = 1'b1; data = fw[i]; sof = (i == 0); eof = (i == n - 1);
            if (i == n - 1) begin
                addr = A_STAT; #1 pre = rdata;
                if (clr_last) begin addr = A_CLR; wr = 1'b1; wdata = 32'h1; end
            end
        end
        @(negedge clk); vld = 1'b0; sof = 1'b0; eof = 1'b0; wr = 1'b0; wdata = '0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_STAT, v); check("R1 status", v, 0);
        rd(A_CTL, v);  check("R1 flag/enable", v, 0);
        check("R1 irq", {31'b0, irq}, 0);
    endtask

    task automatic t_min();
        logic [31:0] v, pre, e;
        fill(32'h01234567); e = model(16);
        frame(16, 0, 0, pre);
        check("R5 status before closing edge", pre, 0);
        rd(A_STAT, v); check("R12 R2 16-word checksum", v, e);
        rd(A_CTL, v);  check("R6 flag set", v, 32'h1);
        check("R8 irq masked", {31'b0, irq}, 0);
        repeat (5) @(negedge clk);
        rd(A_STAT, v); check("R5 hold while idle", v, e);
    endtask

    task automatic t_irq_clear();
        logic [31:0] v;
        wreg(A_CTL, 32'h2);
        rd(A_CTL, v); check("R8 enable readback", v, 32'h3);
        check("R8 irq high", {31'b0, irq}, 1);
        wreg(A_CLR, 32'h0);
        rd(A_CTL, v); check("R7 zero write ignored", v, 32'h3);
        wreg(A_CLR, 32'h1);
        rd(A_CTL, v); check("R7 flag cleared", v, 32'h2);
        check("R8 irq low after clear", {31'b0, irq}, 0);
    endtask

    task automatic t_gaps();
        logic [31:0] v, pre, e;
        fill(32'hA5A50F0F); e = model(24);
        frame(24, 3, 0, pre);
        rd(A_STAT, v); check("R4 gaps ignored", v, e);
        wreg(A_CLR, 32'h1);
    endtask

    task automatic t_overwrite();
        logic [31:0] v, pre, ea, eb;
        fill(32'h11111111); ea = model(20);
        frame(20, 0, 0, pre);
        fill(32'h7FFF0001); eb = model(16);
        frame(16, 0, 0, pre);
        check("R5 old value until closing edge", pre, ea);
        rd(A_STAT, v); check("R10 overwritten", v, eb);
        rd(A_CTL, v);  check("R10 flag still set", v[0], 1);
        fill(32'h11111111);
        frame(20, 0, 0, pre);
        rd(A_STAT, v); check("R3 reseeded per frame", v, ea);
        wreg(A_CLR, 32'h1);
    endtask

    task automatic t_stray_restart();
        logic [31:0] v, pre, e;
        rd(A_STAT, e);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); vld = 1'b1; data = 32'hDEAD0000 + i; eof = (i == 5);
        end
        @(negedge clk); vld = 1'b0; eof = 1'b0;
        rd(A_STAT, v); check("R11 stray words status", v, e);
        rd(A_CTL, v);  check("R11 stray words flag", v[0], 0);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); vld = 1'b1; data = 32'hCAFE0000 + i; sof = (i == 0);
        end
        fill(32'h0BADF00D); e = model(16);
        frame(16, 0, 0, pre);
        rd(A_STAT, v); check("R11 restart on inner start", v, e);
        wreg(A_CLR, 32'h1);
    endtask

    task automatic t_readonly();
        logic [31:0] v, e;
        rd(A_STAT, e);
        wreg(A_STAT, 32'h5A5A5A5A);
        rd(A_STAT, v); check("R9 write to status ignored", v, e);
    endtask

    task automatic t_race();
        logic [31:0] v, pre;
        fill(32'h3C3C3C3C);
        frame(16, 0, 1, pre);
        rd(A_CTL, v); check("R13 set wins over clear", v[0], 1);
        wreg(A_CLR, 32'h1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_NS * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        #(CLK_NS * 2 + 3);
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        t_min();
        t_irq_clear();
        t_gaps();
        t_overwrite();
        t_stray_restart();
        t_readonly();
        t_race();
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule